// File: doc/BRIEF.md
# YUV 4:2:2 Byte-Pair Packer

This block sits behind a camera pixel port that carries 4:2:2 video as a stream of 8-bit samples. Within each active line the samples alternate between chroma and luma, so two pixels take four bytes and one U and one V sample are shared by a pair of adjacent luma samples. The packer joins each chroma byte with its luma partner into one 16-bit word, with luma in the upper half and chroma in the lower half. A frame store can then be written 16 bits wide at half the byte rate. A tag on each word says whether its chroma is U or V.

The byte phase restarts at every rising edge of the line-active qualifier, so one lost byte cannot shift the luma and chroma positions in later lines. An order input selects chroma-first (C, Y, C, Y) or luma-first (Y, C, Y, C) streams. If a line ends on an unpaired byte, that byte is dropped and an error pulse is raised. Codes 0x00 and 0xFF are reserved on the bus, and a status pulse flags any accepted byte that carries one of them. Chroma is offset binary centred on 0x80 and passes through unchanged.

Top module: `yuv_pair_packer`

## Requirements
- R1: After reset, word_valid, chroma_is_v, line_error and reserved_hit are all 0.
- R2: With order_swap = 0, the first accepted byte of a pair is chroma and the second is luma. word_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the second byte, and word_data = {luma, chroma}, with luma in bits [15:8] and chroma in bits [7:0].
- R3: With order_swap = 1, the first accepted byte of a pair is luma and the second is chroma. The word layout is still {luma, chroma}, luma in bits [15:8].
- R4: chroma_is_v is 0 (U) on the first word of each line and inverts on every later word of the same line.
- R5: A rising edge of line_active resets the byte phase and the U/V alternation, whatever state the previous line left.
- R6: If line_active falls while a byte is waiting for its partner, that byte produces no word. line_error is high for one cycle, in the cycle after the first edge at which line_active is sampled low. A line with an even byte count leaves line_error at 0.
- R7: An accepted byte equal to 0x00 or 0xFF sets reserved_hit for one cycle, in the cycle after it is accepted. The byte is still packed normally. Any other value leaves reserved_hit at 0.
- R8: A byte is accepted only on a clock edge where byte_valid and line_active are both 1. Bytes sampled with either signal low produce no word and do not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | byte_data carries a sample this cycle |
| line_active | input | 1 | Line-active qualifier; high during active video of a line |
| byte_data | input | 8 | Incoming sample byte |
| order_swap | input | 1 | 0: chroma-first order, 1: luma-first order |
| word_valid | output | 1 | One-cycle strobe marking a packed word |
| word_data | output | 16 | {luma, chroma} |
| chroma_is_v | output | 1 | Chroma type of the word: 0 = U, 1 = V |
| line_error | output | 1 | One-cycle pulse: line ended on an unpaired byte |
| reserved_hit | output | 1 | One-cycle pulse: accepted byte was 0x00 or 0xFF |

## Verification
All three result outputs come from registers and are due exactly one cycle after their cause. A word appears after the edge that accepts the second byte of a pair. reserved_hit appears after the edge that accepts the offending byte. line_error appears after the first edge at which line_active is seen low. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check looks at the single cycle in which its result is due. The cycles in between are checked to be quiet.

// File: rtl/yuv_pair_pkg.sv
package yuv_pair_pkg;

    // Position inside a chroma/luma pair
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_e;

    // Byte order on the camera bus
    typedef enum logic {
        ORD_CHROMA_FIRST = 1'b0,
        ORD_LUMA_FIRST   = 1'b1
    } byte_order_e;

endpackage

// File: rtl/yuv_line_edge.sv
module yuv_line_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_active,
    output logic line_start,
    output logic line_end
);

    logic act_d, act_q;

    always_comb begin
        act_d      = line_active;
        line_start = line_active && !act_q;
        line_end   = !line_active && act_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

endmodule

// File: rtl/yuv_code_check.sv
module yuv_code_check #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] byte_in,
    output logic              reserved_hit
);

    localparam int NUM_CODES = 2;
    localparam logic [DATA_W-1:0] CODE_TAB [NUM_CODES] = '{
        {DATA_W{1'b0}}, {DATA_W{1'b1}}
    };

    logic [NUM_CODES-1:0] match;
    logic hit_d, hit_q;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        assign match[g] = (byte_in == CODE_TAB[g]);
    end

    always_comb begin
        hit_d = accept && (|match);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assign reserved_hit = hit_q;

endmodule

// File: rtl/yuv_pair_core.sv
module yuv_pair_core
    import yuv_pair_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] byte_in,
    input  byte_order_e       order,
    input  logic              line_start,
    input  logic              line_end,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              chroma_is_v,
    output logic              line_error
);

    typedef struct packed {
        pair_phase_e       phase;
        logic [DATA_W-1:0] held;
        logic              v_next;
        logic              out_valid;
        logic [WORD_W-1:0] out_word;
        logic              out_v;
        logic              err;
    } core_t;

    core_t       st_d, st_q;
    pair_phase_e ph;
    logic        vsel;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.err       = 1'b0;

        // a new line always begins on the first byte of a pair, with U
        ph   = line_start ? PH_FIRST : st_q.phase;
        vsel = line_start ? 1'b0     : st_q.v_next;
        st_d.phase  = ph;
        st_d.v_next = vsel;

        if (accept) begin
            if (ph == PH_FIRST) begin
                st_d.held  = byte_in;
                st_d.phase = PH_SECOND;
            end else begin
                st_d.phase     = PH_FIRST;
                st_d.out_valid = 1'b1;
                st_d.out_v     = vsel;
                st_d.v_next    = !vsel;
                if (order == ORD_LUMA_FIRST) st_d.out_word = {st_q.held, byte_in};
                else                         st_d.out_word = {byte_in, st_q.held};
            end
        end

        // line closes: a waiting half-pair is dropped and reported
        if (line_end) begin
            st_d.err   = (st_q.phase == PH_SECOND);
            st_d.phase = PH_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid  = st_q.out_valid;
    assign word_data   = st_q.out_word;
    assign chroma_is_v = st_q.out_v;
    assign line_error  = st_q.err;

endmodule

// File: rtl/yuv_pair_packer.sv
module yuv_pair_packer
    import yuv_pair_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              line_active,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              order_swap,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              chroma_is_v,
    output logic              line_error,
    output logic              reserved_hit
);

    logic        accept;
    logic        line_start, line_end;
    byte_order_e order;

    assign accept = byte_valid && line_active;
    assign order  = order_swap ? ORD_LUMA_FIRST : ORD_CHROMA_FIRST;

    yuv_line_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (line_active),
        .line_start  (line_start),
        .line_end    (line_end)
    );

    yuv_code_check #(.DATA_W(DATA_W)) u_code (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .byte_in      (byte_data),
        .reserved_hit (reserved_hit)
    );

    yuv_pair_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .byte_in     (byte_data),
        .order       (order),
        .line_start  (line_start),
        .line_end    (line_end),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .chroma_is_v (chroma_is_v),
        .line_error  (line_error)
    );

endmodule

// File: rtl/yuv_pair_checker.sv
module yuv_pair_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              line_active,
    input logic [DATA_W-1:0] byte_data,
    input logic              word_valid,
    input logic              chroma_is_v,
    input logic              line_error,
    input logic              reserved_hit
);

    logic act_q, seen_q, last_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            seen_q   <= 1'b0;
            last_v_q <= 1'b0;
        end else begin
            act_q <= line_active;
            if (line_active && !act_q) seen_q <= 1'b0;
            else if (word_valid)       seen_q <= 1'b1;
            if (word_valid) last_v_q <= chroma_is_v;
        end
    end

    AST_WORD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(byte_valid && line_active)); // R8

    AST_FIRST_WORD_U: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !seen_q) |-> !chroma_is_v); // R4

    AST_UV_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && seen_q) |-> (chroma_is_v != last_v_q)); // R4

    AST_ERR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        line_error |-> ($past(act_q) && !$past(line_active))); // R6

    AST_ERR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        line_error |-> !word_valid); // R6

    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && line_active &&
         (byte_data == {DATA_W{1'b0}} || byte_data == {DATA_W{1'b1}})) |=> reserved_hit); // R7

endmodule

bind yuv_pair_packer yuv_pair_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .line_active  (line_active),
    .byte_data    (byte_data),
    .word_valid   (word_valid),
    .chroma_is_v  (chroma_is_v),
    .line_error   (line_error),
    .reserved_hit (reserved_hit)
);

// File: tb/sim_yuv_pair_packer.sv
`timescale 1ns/1ps
module sim_yuv_pair_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        line_active = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        order_swap = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        chroma_is_v;
    logic        line_error;
    logic        reserved_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    yuv_pair_packer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .line_active  (line_active),
        .byte_data    (byte_data),
        .order_swap   (order_swap),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .chroma_is_v  (chroma_is_v),
        .line_error   (line_error),
        .reserved_hit (reserved_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, return at next falling edge
    task automatic step(input logic v, input logic a, input logic [7:0] d);
        byte_valid  = v;
        line_active = a;
        byte_data   = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_word(input string tag, input logic [15:0] w, input logic v);
        chk({tag, " word_valid"}, word_valid, 1);
        chk({tag, " word_data"}, word_data, w);
        chk({tag, " chroma_is_v"}, chroma_is_v, v);
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " no word"}, word_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 word_valid", word_valid, 0);
        chk("R1 chroma_is_v", chroma_is_v, 0);
        chk("R1 line_error", line_error, 0);
        chk("R1 reserved_hit", reserved_hit, 0);
    endtask

    task automatic t_default_order();
        order_swap = 1'b0;
        step(1, 1, 8'h80); expect_none("R2 first byte");
        step(1, 1, 8'h40); expect_word("R2 U pair", 16'h4080, 0);
        step(1, 1, 8'h90); expect_none("R2 third byte");
        step(1, 1, 8'h41); expect_word("R4 V pair", 16'h4190, 1);
        step(1, 1, 8'h7F); expect_none("R2 fifth byte");
        step(1, 1, 8'h42); expect_word("R4 U again", 16'h427F, 0);
        step(0, 0, 8'h00); chk("R6 even line no error", line_error, 0);
        expect_none("R2 after line");
        step(0, 0, 8'h00);
    endtask

    task automatic t_swapped_order();
        order_swap = 1'b1;
        step(1, 1, 8'h10); expect_none("R3 luma first");
        step(1, 1, 8'h70); expect_word("R3 Y,U pair", 16'h1070, 0);
        step(1, 1, 8'h11);
        step(1, 1, 8'h60); expect_word("R3 Y,V pair", 16'h1160, 1);
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        order_swap = 1'b0;
    endtask

    task automatic t_odd_line();
        step(1, 1, 8'h81);
        step(1, 1, 8'h50); expect_word("R6 pair before odd", 16'h5081, 0);
        step(1, 1, 8'h82); expect_none("R6 lone byte");
        step(0, 0, 8'h00);
        chk("R6 line_error pulse", line_error, 1);
        expect_none("R6 dropped byte");
        step(0, 0, 8'h00);
        chk("R6 line_error one cycle", line_error, 0);
        // next line must start clean: chroma first, U
        step(1, 1, 8'h55); expect_none("R5 first byte new line");
        step(1, 1, 8'h22); expect_word("R5 realigned", 16'h2255, 0);
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
    endtask

    task automatic t_ignored_bytes();
        // bytes outside the line
        step(1, 0, 8'h33); expect_none("R8 outside line");
        step(1, 0, 8'h34); expect_none("R8 outside line 2");
        // gaps inside a line
        step(1, 1, 8'h84);
        step(0, 1, 8'hEE); expect_none("R8 gap");
        step(0, 1, 8'hEF); expect_none("R8 gap 2");
        step(1, 1, 8'h60); expect_word("R8 pair across gap", 16'h6084, 0);
        step(0, 1, 8'h00); expect_none("R8 gap 3");
        step(1, 1, 8'h86);
        step(1, 1, 8'h61); expect_word("R8 second pair", 16'h6186, 1);
        step(0, 0, 8'h00); chk("R8 no error after gaps", line_error, 0);
        step(0, 0, 8'h00);
    endtask

    task automatic t_reserved();
        step(1, 1, 8'h00); chk("R7 zero flagged", reserved_hit, 1);
        step(1, 1, 8'hFF); chk("R7 max flagged", reserved_hit, 1);
        expect_word("R7 still packed", 16'hFF00, 0);
        step(1, 1, 8'h01); chk("R7 near code clear", reserved_hit, 0);
        step(1, 1, 8'hFE); chk("R7 near max clear", reserved_hit, 0);
        expect_word("R7 normal pair", 16'hFE01, 1);
        step(0, 0, 8'h00); chk("R7 pulse ends", reserved_hit, 0);
        step(0, 1, 8'h00);
        step(1, 0, 8'hFF); chk("R8 ignored reserved", reserved_hit, 0);
        step(0, 0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_order();
        t_swapped_order();
        t_odd_line();
        t_ignored_bytes();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule